// File: doc/BRIEF.md
# BCD Time-of-Day Clock Register Block

This block keeps calendar time in packed BCD (two decimal digits per byte, tens digit in bits 7:4, units in bits 3:0) and advances it by one second on every cycle in which the one-pulse-per-second tick input is high. Software reaches it through a byte-wide, memory-mapped window: eight registers occupy the eight highest addresses of an `ADDR_W`-bit space. Every other address reads as zero, and writes to those addresses are ignored.

A control register coordinates software access. Its read-freeze bit holds the readable copy still, so that a multi-byte read stays coherent while the internal counters keep running. Its write-hold bit stops counting and sends time writes into a staging copy. Clearing that bit transfers the staged time into the counters in one step. Spare upper bits of three time registers store flags: a stop bit that gates the tick, a kick-start flag and a frequency-test flag. The control register also holds a calibration sign bit, which has no effect on counting.

Top module: `tod_clock_regs`

## Requirements
- R1: Registers sit at addresses `2^ADDR_W-8` (offset 0) through `2^ADDR_W-1` (offset 7). The order is: control, seconds, minutes, hours, day-of-week, date, month, year. Any other address reads 0x00, and writes to it change no register.
- R2: After reset the registers read: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day-of-week 0x01, date 0x01, month 0x01, year 0x00. All flags are clear.
- R3: Each cycle with `tick_i` high advances seconds by one in BCD, with units carrying into tens (for example, 0x09 goes to 0x10). The visible copy follows the counters one clock later.
- R4: Carries ripple in this order. Seconds 0x59 wraps to 0x00 and steps minutes. Minutes 0x59 wraps and steps hours. Hours 0x23 wraps to 0x00 and steps the day.
- R5: Date wraps to 0x01 after the last day of the month, and the month then steps. Months 0x04, 0x06, 0x09 and 0x11 have 30 days. Month 0x02 has 29 days when the decimal year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R6: Day-of-week wraps from 0x07 to 0x01. Month wraps from 0x12 to 0x01 and steps the year. Year wraps from 0x99 to 0x00.
- R7: Writes keep only the value bits of each register: seconds and minutes bits 6:0, hours 5:0, day-of-week 2:0, date 5:0, month 4:0, year 7:0. All other bits read 0 unless they hold a flag.
- R8: Seconds bit 7 is a stop flag. While it is 1, ticks do not advance the time.
- R9: Control bit 6 is read-freeze. While it is 1, the time fields read back unchanged and the counters keep counting. In the second cycle after the bit is written back to 0, reads show the running counters.
- R10: Control bit 7 is write-hold. Setting it (from 0) copies the counters into a staging copy. While it is 1, ticks are dropped and time writes go only to the staging copy. Writing control with bit 7 = 0 while it is 1 loads the staged time into the counters.
- R11: While write-hold is 0, a time write goes straight to the counters. If a tick arrives in the same cycle as that write, the write wins and the tick is dropped.
- R12: Hours bit 7 (kick-start), day-of-week bit 6 (frequency test) and control bit 5 (sign) are stored as read/write bits that take effect at once and have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| wr_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W | Byte address within the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |

## Verification
A corrupted counter or staging value surfaces on `rdata_o` one clock after the edge that made it, because the visible copy tracks the counters with a one-cycle lag. The only exception is while read-freeze is set, when the error stays hidden until the cycle after release. A carry fault in the rollover chain shows up on the tick that crosses the boundary, so the bench jumps straight to each boundary (month ends, leap February, year end) by writing the time directly. The bench scans the addresses every cycle and compares each read with a behavioural model, so a wrong flag, a misplaced commit or a dropped tick shows up within a few cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int TOD_NREG  = 8;
   localparam int TOD_IDX_W = $clog2(TOD_NREG);

   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] mday;
      logic [7:0] wday;
      logic [7:0] hrs;
      logic [7:0] mins;
      logic [7:0] secs;
   } tod_time_t;

   localparam tod_time_t TOD_RESET = '{yr: 8'h00, mon: 8'h01, mday: 8'h01,
                                       wday: 8'h01, hrs: 8'h00, mins: 8'h00,
                                       secs: 8'h00};

   typedef enum logic [2:0] {
      IX_CTRL = 3'd0, IX_SEC = 3'd1, IX_MIN = 3'd2, IX_HR = 3'd3,
      IX_WDAY = 3'd4, IX_MDAY = 3'd5, IX_MON = 3'd6, IX_YR = 3'd7
   } tod_idx_e;

   // value bits kept per register; flags are not part of the mask
   function automatic logic [7:0] field_mask(input logic [2:0] ix);
      case (tod_idx_e'(ix))
         IX_SEC, IX_MIN: return 8'h7F;
         IX_HR, IX_MDAY: return 8'h3F;
         IX_WDAY:        return 8'h07;
         IX_MON:         return 8'h1F;
         IX_YR:          return 8'hFF;
         default:        return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] get_field(input tod_time_t t, input logic [2:0] ix);
      case (tod_idx_e'(ix))
         IX_SEC:  return t.secs;
         IX_MIN:  return t.mins;
         IX_HR:   return t.hrs;
         IX_WDAY: return t.wday;
         IX_MDAY: return t.mday;
         IX_MON:  return t.mon;
         IX_YR:   return t.yr;
         default: return 8'h00;
      endcase
   endfunction

   function automatic tod_time_t set_field(input tod_time_t t, input logic [2:0] ix,
                                           input logic [7:0] v);
      tod_time_t r;
      r = t;
      case (tod_idx_e'(ix))
         IX_SEC:  r.secs = v;
         IX_MIN:  r.mins = v;
         IX_HR:   r.hrs  = v;
         IX_WDAY: r.wday = v;
         IX_MDAY: r.mday = v;
         IX_MON:  r.mon  = v;
         IX_YR:   r.yr   = v;
         default: r = t;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last date of a month, BCD; leap test on the decimal year value
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      logic [7:0] ybin;
      ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
      case (mon)
         8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/tod_addr_decode.sv
module tod_addr_decode #(
   parameter int ADDR_W = 11,
   parameter int NREG   = 8,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [NREG-1:0]   we_o
);

   generate
      if (NREG != (1 << IDX_W)) begin : g_bad_nreg
         $error("tod_addr_decode: NREG must be a power of two");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("tod_addr_decode: ADDR_W must exceed the index width");
      end
   endgenerate

   // window occupies the top NREG addresses
   assign hit_o = &addr_i[ADDR_W-1:IDX_W];
   assign idx_o = addr_i[IDX_W-1:0];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_we
      assign we_o[gi] = wr_i && hit_o && (idx_o == IDX_W'(gi));
   end

endmodule

// File: rtl/tod_advance.sv
module tod_advance
   import tod_pkg::*;
(
   input  tod_time_t cur_i,
   output tod_time_t nxt_o
);

   logic [7:0] last_day;

   always_comb begin
      last_day = month_last(cur_i.mon, cur_i.yr);
      nxt_o    = cur_i;
      if (cur_i.secs >= 8'h59) begin
         nxt_o.secs = 8'h00;
         if (cur_i.mins >= 8'h59) begin
            nxt_o.mins = 8'h00;
            if (cur_i.hrs >= 8'h23) begin
               nxt_o.hrs  = 8'h00;
               nxt_o.wday = (cur_i.wday >= 8'h07) ? 8'h01 : bcd_step(cur_i.wday);
               if (cur_i.mday >= last_day) begin
                  nxt_o.mday = 8'h01;
                  if (cur_i.mon >= 8'h12) begin
                     nxt_o.mon = 8'h01;
                     nxt_o.yr  = (cur_i.yr >= 8'h99) ? 8'h00 : bcd_step(cur_i.yr);
                  end else begin
                     nxt_o.mon = bcd_step(cur_i.mon);
                  end
               end else begin
                  nxt_o.mday = bcd_step(cur_i.mday);
               end
            end else begin
               nxt_o.hrs = bcd_step(cur_i.hrs);
            end
         end else begin
            nxt_o.mins = bcd_step(cur_i.mins);
         end
      end else begin
         nxt_o.secs = bcd_step(cur_i.secs);
      end
   end

endmodule

// File: rtl/tod_hold_reg.sv
module tod_hold_reg #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST;
      else if (en_i) q_o <= d_i;
   end

endmodule

// File: rtl/tod_clock_regs.sv
module tod_clock_regs
   import tod_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o
);

   localparam int TW = $bits(tod_time_t);

   logic                 hit;
   logic [TOD_IDX_W-1:0] idx;
   logic [TOD_NREG-1:0]  we;

   logic wbit_q, rbit_q, sign_q;
   logic stop_q, kick_q, ftest_q;

   tod_time_t cnt_q, cnt_d, stage_q, stage_d, adv_t, snap_q;
   logic [TW-1:0] snap_raw;

   logic       time_we, adv, commit, load_stage;
   logic [7:0] fld, rd_field, rd_flags;

   tod_addr_decode #(.ADDR_W(ADDR_W), .NREG(TOD_NREG)) u_dec (
      .addr_i (addr_i),
      .wr_i   (wr_i),
      .hit_o  (hit),
      .idx_o  (idx),
      .we_o   (we)
   );

   tod_advance u_adv (
      .cur_i (cnt_q),
      .nxt_o (adv_t)
   );

   // visible copy: follows counters unless read-freeze is set
   tod_hold_reg #(.W(TW), .RST(TOD_RESET)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (!rbit_q),
      .d_i   (cnt_q),
      .q_o   (snap_raw)
   );
   assign snap_q = snap_raw;

   assign time_we    = |we[TOD_NREG-1:1];
   assign fld        = wdata_i & field_mask(idx);
   assign adv        = tick_i && !wbit_q && !stop_q && !time_we;
   assign commit     = we[IX_CTRL] && wbit_q && !wdata_i[7];
   assign load_stage = we[IX_CTRL] && !wbit_q && wdata_i[7];

   always_comb begin
      cnt_d = cnt_q;
      if (commit)                   cnt_d = stage_q;
      else if (time_we && !wbit_q)  cnt_d = set_field(cnt_q, idx, fld);
      else if (adv)                 cnt_d = adv_t;
   end

   always_comb begin
      stage_d = stage_q;
      if (load_stage)              stage_d = cnt_q;
      else if (time_we && wbit_q)  stage_d = set_field(stage_q, idx, fld);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= TOD_RESET;
         stage_q <= TOD_RESET;
      end else begin
         cnt_q   <= cnt_d;
         stage_q <= stage_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbit_q  <= 1'b0;
         rbit_q  <= 1'b0;
         sign_q  <= 1'b0;
         stop_q  <= 1'b0;
         kick_q  <= 1'b0;
         ftest_q <= 1'b0;
      end else begin
         if (we[IX_CTRL]) begin
            wbit_q <= wdata_i[7];
            rbit_q <= wdata_i[6];
            sign_q <= wdata_i[5];
         end
         if (we[IX_SEC])  stop_q  <= wdata_i[7];
         if (we[IX_HR])   kick_q  <= wdata_i[7];
         if (we[IX_WDAY]) ftest_q <= wdata_i[6];
      end
   end

   always_comb begin
      rd_field = get_field(snap_q, idx) & field_mask(idx);
      case (tod_idx_e'(idx))
         IX_CTRL: rd_flags = {wbit_q, rbit_q, sign_q, 5'b0};
         IX_SEC:  rd_flags = {stop_q, 7'b0};
         IX_HR:   rd_flags = {kick_q, 7'b0};
         IX_WDAY: rd_flags = {1'b0, ftest_q, 6'b0};
         default: rd_flags = 8'h00;
      endcase
      rdata_o = hit ? (rd_field | rd_flags) : 8'h00;
   end

endmodule

// File: rtl/tod_checker.sv
module tod_checker
   import tod_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       wr,
   input logic       hit,
   input logic       wbit,
   input logic       rbit,
   input logic       stop,
   input tod_time_t  cnt,
   input tod_time_t  snap,
   input logic [7:0] rdata
);

   assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> rdata == 8'h00);

   assert_tick_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wbit && !stop && !wr) |=> cnt != $past(cnt));

   assert_stop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr) |=> cnt == $past(cnt));

   assert_snap_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rbit |=> snap == $past(cnt));

   assert_snap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rbit |=> $stable(snap));

   assert_hold_counters_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wbit && !wr) |=> cnt == $past(cnt));

endmodule

bind tod_clock_regs tod_checker u_tod_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (tick_i),
   .wr    (wr_i),
   .hit   (hit),
   .wbit  (wbit_q),
   .rbit  (rbit_q),
   .stop  (stop_q),
   .cnt   (cnt_q),
   .snap  (snap_q),
   .rdata (rdata_o)
);

// File: tb/tod_clock_regs_bench.sv
module tod_clock_regs_bench;

   localparam int CLK_P = 10;
   localparam int AW    = 11;
   localparam int WD    = 20000;
   localparam logic [AW-1:0] BASE = AW'((1 << AW) - 8);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          b_tick = 1'b0;
   logic          b_wr = 1'b0;
   logic [AW-1:0] b_addr = BASE;
   logic [7:0]    b_wd = 8'h00;
   logic [7:0]    rdata;

   int    checks = 0;
   int    errors = 0;
   int    scan = 0;
   bit    cmp_en = 1'b0;
   string cur_req = "R2";

   // behavioural model: binary values, index 1..7 = sec..year
   int mt[8];
   int st[8];
   int sn[8];
   bit m_wb, m_rb, m_sg, m_stop, m_kick, m_ft;

   always #(CLK_P/2) clk = ~clk;

   tod_clock_regs #(.ADDR_W(AW)) u_tod_clock_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (b_tick),
      .wr_i    (b_wr),
      .addr_i  (b_addr),
      .wdata_i (b_wd),
      .rdata_o (rdata)
   );

   function automatic int mask_of(int ix);
      case (ix)
         1, 2:    return 'h7F;
         3, 5:    return 'h3F;
         4:       return 'h07;
         6:       return 'h1F;
         7:       return 'hFF;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(int v);
      return (v >> 4) * 10 + (v & 15);
   endfunction

   function automatic int days_in(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) mt[i] = 0;
      mt[4] = 1; mt[5] = 1; mt[6] = 1;
      st = mt;
      sn = mt;
      {m_wb, m_rb, m_sg, m_stop, m_kick, m_ft} = '0;
   endtask

   task automatic model_advance();
      mt[1]++;
      if (mt[1] < 60) return;
      mt[1] = 0; mt[2]++;
      if (mt[2] < 60) return;
      mt[2] = 0; mt[3]++;
      if (mt[3] < 24) return;
      mt[3] = 0;
      mt[4] = (mt[4] == 7) ? 1 : mt[4] + 1;
      if (mt[5] < days_in(mt[6], mt[7])) begin mt[5]++; return; end
      mt[5] = 1;
      if (mt[6] < 12) begin mt[6]++; return; end
      mt[6] = 1;
      mt[7] = (mt[7] + 1) % 100;
   endtask

   task automatic model_step();
      bit hit, tw, adv;
      int ix;
      hit = (b_addr[AW-1:3] == '1);
      ix  = int'(b_addr[2:0]);
      tw  = b_wr && hit && ix != 0;
      adv = b_tick && !m_wb && !m_stop && !tw;
      if (!m_rb) sn = mt;
      if (b_wr && hit && ix == 0) begin
         if (!m_wb && b_wd[7]) st = mt;
         if (m_wb && !b_wd[7]) mt = st;
         m_wb = b_wd[7]; m_rb = b_wd[6]; m_sg = b_wd[5];
      end
      if (tw) begin
         if (ix == 1) m_stop = b_wd[7];
         if (ix == 3) m_kick = b_wd[7];
         if (ix == 4) m_ft   = b_wd[6];
         if (m_wb) st[ix] = from_bcd(int'(b_wd) & mask_of(ix));
         else      mt[ix] = from_bcd(int'(b_wd) & mask_of(ix));
      end
      if (adv) model_advance();
   endtask

   function automatic logic [7:0] model_read(logic [AW-1:0] a);
      int ix;
      if (a[AW-1:3] != '1) return 8'h00;
      ix = int'(a[2:0]);
      case (ix)
         0:       return {m_wb, m_rb, m_sg, 5'b0};
         1:       return {m_stop, 7'b0} | to_bcd(sn[1]);
         3:       return {m_kick, 7'b0} | to_bcd(sn[3]);
         4:       return {1'b0, m_ft, 6'b0} | to_bcd(sn[4]);
         default: return to_bcd(sn[ix]);
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // cycle-by-cycle comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (rst_n && cmp_en) begin
         logic [7:0] exp;
         exp = model_read(b_addr);
         checks++;
         if (rdata !== exp) begin
            errors++;
            $display("FAIL %s model compare addr=%0h actual=%02h expected=%02h",
                     cur_req, b_addr, rdata, exp);
         end
      end
   end

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         b_wr = 1'b0; b_tick = 1'b0;
         b_addr = BASE + AW'(scan);
         scan = (scan + 1) % 8;
      end
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         @(negedge clk);
         b_wr = 1'b0; b_tick = 1'b1;
         b_addr = BASE + AW'(scan);
         scan = (scan + 1) % 8;
      end
   endtask

   task automatic wr_raw(logic [AW-1:0] a, logic [7:0] d, bit t = 1'b0);
      @(negedge clk);
      b_addr = a; b_wd = d; b_wr = 1'b1; b_tick = t;
   endtask

   task automatic wrreg(int ix, logic [7:0] d, bit t = 1'b0);
      wr_raw(BASE + AW'(ix), d, t);
   endtask

   task automatic chk_raw(logic [AW-1:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      b_addr = a; b_wr = 1'b0; b_tick = 1'b0;
      #1;
      checks++;
      if (rdata !== exp) begin
         errors++;
         $display("FAIL %s addr=%0h actual=%02h expected=%02h", tag, a, rdata, exp);
      end
   endtask

   task automatic chk(int ix, logic [7:0] exp, string tag);
      chk_raw(BASE + AW'(ix), exp, tag);
   endtask

   task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                           logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
      wrreg(1, s); wrreg(2, mi); wrreg(3, h); wrreg(4, dw);
      wrreg(5, dt); wrreg(6, mo); wrreg(7, y);
      idle(1);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R2 reset state
      cur_req = "R2";
      chk(0, 8'h00, "R2"); chk(1, 8'h00, "R2"); chk(2, 8'h00, "R2");
      chk(3, 8'h00, "R2"); chk(4, 8'h01, "R2"); chk(5, 8'h01, "R2");
      chk(6, 8'h01, "R2"); chk(7, 8'h00, "R2");

      // R3 BCD seconds counting
      cur_req = "R3";
      ticks(10); idle(2);
      chk(1, 8'h10, "R3");

      // R4 seconds carry into minutes
      cur_req = "R4";
      ticks(50); idle(2);
      chk(1, 8'h00, "R4"); chk(2, 8'h01, "R4");

      // R4 R5 R6 full day rollover, non-leap February
      cur_req = "R4";
      set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
      ticks(2); idle(2);
      chk(1, 8'h00, "R4"); chk(2, 8'h00, "R4"); chk(3, 8'h00, "R4");
      chk(4, 8'h01, "R6"); chk(5, 8'h01, "R5"); chk(6, 8'h03, "R5");
      chk(7, 8'h23, "R5");

      // R5 leap February
      cur_req = "R5";
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
      ticks(1); idle(2);
      chk(5, 8'h29, "R5"); chk(6, 8'h02, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
      ticks(1); idle(2);
      chk(5, 8'h01, "R5"); chk(6, 8'h03, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24);
      ticks(1); idle(2);
      chk(5, 8'h01, "R5"); chk(6, 8'h05, "R5");
      set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h01, 8'h24);
      ticks(1); idle(2);
      chk(5, 8'h31, "R5"); chk(4, 8'h07, "R6");

      // R6 year end
      cur_req = "R6";
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      ticks(1); idle(2);
      chk(5, 8'h01, "R6"); chk(6, 8'h01, "R6"); chk(7, 8'h00, "R6");
      chk(4, 8'h01, "R6");

      // R8 stop flag
      cur_req = "R8";
      wrreg(1, 8'h85); ticks(5); idle(2);
      chk(1, 8'h85, "R8");
      wrreg(1, 8'h05); ticks(3); idle(2);
      chk(1, 8'h08, "R8");

      // R9 read-freeze
      cur_req = "R9";
      wrreg(1, 8'h10); wrreg(0, 8'h40); ticks(5); idle(2);
      chk(1, 8'h10, "R9"); chk(0, 8'h40, "R9");
      wrreg(0, 8'h00);
      chk(1, 8'h10, "R9");
      chk(1, 8'h15, "R9");

      // R10 write-hold staging and commit
      cur_req = "R10";
      wrreg(2, 8'h20); wrreg(0, 8'h80); wrreg(2, 8'h33); ticks(4); idle(2);
      chk(2, 8'h20, "R10"); chk(1, 8'h15, "R10"); chk(0, 8'h80, "R10");
      wrreg(0, 8'h00); idle(2);
      chk(2, 8'h33, "R10"); chk(1, 8'h15, "R10"); chk(0, 8'h00, "R10");

      // R11 direct write wins over same-cycle tick
      cur_req = "R11";
      wrreg(1, 8'h40, 1'b1); idle(2);
      chk(1, 8'h40, "R11");
      ticks(1); idle(2);
      chk(1, 8'h41, "R11");

      // R7 write masking
      cur_req = "R7";
      wrreg(5, 8'hD9); wrreg(2, 8'hC5); wrreg(6, 8'hE9); wrreg(3, 8'h52);
      wrreg(4, 8'hB5); idle(2);
      chk(5, 8'h19, "R7"); chk(2, 8'h45, "R7"); chk(6, 8'h09, "R7");
      chk(3, 8'h12, "R7"); chk(4, 8'h05, "R7");

      // R12 stored flags with no counting effect
      cur_req = "R12";
      wrreg(3, 8'h92); wrreg(4, 8'h43); wrreg(0, 8'h20); wrreg(1, 8'h00);
      ticks(3); idle(2);
      chk(3, 8'h92, "R12"); chk(4, 8'h43, "R12"); chk(0, 8'h20, "R12");
      chk(1, 8'h03, "R12");

      // R1 outside the window
      cur_req = "R1";
      wr_raw(AW'(0), 8'hFF); wr_raw(AW'(1), 8'h59); wr_raw(BASE - AW'(1), 8'h12);
      idle(2);
      chk_raw(AW'(0), 8'h00, "R1"); chk_raw(AW'(1), 8'h00, "R1");
      chk_raw(BASE - AW'(1), 8'h00, "R1");
      chk(1, 8'h03, "R1"); chk(0, 8'h20, "R1"); chk(3, 8'h92, "R1");
      chk(6, 8'h09, "R1");

      idle(4);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule